// File: doc/BRIEF.md
# Downstream Port Power and Indicator Controller

This block drives the power switches and the two-colour status lights of up to four downstream hub ports. It senses an active-low over-current line per port and filters it with a debounce counter. When a fault survives the filter, the block removes power from the affected port and latches a change flag. That flag stays set until the hub logic acknowledges it. Power is switched on and off by single-cycle request strobes from the hub's port logic.

The ports can be run in one of two ways:
- **Individual:** each port has its own sensing and its own power switch.
- **Gang:** the port-1 pins carry a single shared switch and a single shared fault line for the whole group.

Each port's lights follow one of two sources:
- **Automatic:** the lights follow power, fault and enable state.
- **Manual:** the lights follow direct colour requests.

Two conditions override the lights. A global suspend turns every light off. When the light pins are shared with a configuration memory, amber is never driven. Only the configured number of ports (2, 3 or 4) is live. The remaining ports stay unpowered and dark.

Top module: `port_pwr_led_ctrl`

## Requirements
- R1: While `rst_n` is low and right after reset, every `pwrEnN` bit is 1 (off), every LED output is 0 and every `ocChange` bit is 0.
- R2: In individual mode, a one-cycle pulse on `pwrSet[p]` drives `pwrEnN[p]` to 0 after the next clock edge, and a pulse on `pwrClr[p]` drives it back to 1; other ports are unaffected.
- R3: An over-current (`ocN[p]` = 0) that is sampled low on DEB_CYCLES consecutive rising edges (default 4) removes power from the port and sets `ocChange[p]` after the last of those edges. A low pulse lasting one cycle fewer has no effect.
- R4: `ocChange[p]` stays set after `ocN[p]` returns high and clears only on a `chgClr[p]` pulse. If a trip and a clear happen in the same cycle, the trip wins. A port keeps its power if it is re-powered while the line is still low, because a trip is a single event per assertion.
- R5: With `gangMode` = 1, only `ocN[0]`, `pwrSet[0]`, `pwrClr[0]` and `chgClr[0]` have effect, and only `pwrEnN[0]` can be 0 (bits 1 and up stay 1). The shared power and fault state is shown on the LEDs and `ocChange` of every active port.
- R6: In automatic mode (`ledManual[p]` = 0), amber is on when the change flag is set. Green is on when the port is powered, `portEn[p]` = 1 and no change flag is set. Otherwise both are off.
- R7: With `ledManual[p]` = 1, green follows `manGreen[p]` and amber follows `manAmber[p]`.
- R8: While `suspend` = 1, all LED outputs are 0; power outputs are unchanged.
- R9: While `eepromPresent` = 1, all amber outputs are 0; green is unaffected.
- R10: Port p is active when p < the effective port count. The effective count is `portCount` clamped to the range 2 to 4: values below 2 act as 2 and values above 4 act as 4. Inactive ports lose power and their change flag at the next edge, keep LEDs off, and ignore requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ocN | input | 4 | Active-low over-current sense, one per port |
| gangMode | input | 1 | 1 = gang power/sense on port 1 pins, 0 = individual |
| portCount | input | 3 | Configured number of live ports (clamped to 2..4) |
| pwrSet | input | 4 | One-cycle request to power a port |
| pwrClr | input | 4 | One-cycle request to unpower a port |
| chgClr | input | 4 | One-cycle acknowledge of a port's change flag |
| portEn | input | 4 | Port enabled by the port state logic |
| ledManual | input | 4 | 1 = manual light control for the port |
| manGreen | input | 4 | Manual green request |
| manAmber | input | 4 | Manual amber request |
| suspend | input | 1 | Global suspend, forces lights dark |
| eepromPresent | input | 1 | Light pins shared with a memory; suppress amber |
| pwrEnN | output | 4 | Active-low power enable per port |
| ledGreen | output | 4 | Green light drive |
| ledAmber | output | 4 | Amber light drive |
| ocChange | output | 4 | Latched over-current change flag |

## Verification
The hardest case to set up is a trip landing in the same cycle as a flag acknowledge. The stimulus holds one port's sense line low for exactly the debounce length and raises `chgClr` on the final cycle, so that the clear and the trip coincide. A glitch one cycle short of the filter is also applied, so that an off-by-one in the counter shows at the outputs. Port-count shrinking is exercised while a power request targets a port that is being retired. Gang mode is entered with individual ports already powered, and the non-port-1 sense lines are then held low long enough to trip if they were wrongly sensed.

// File: rtl/ppl_pkg.sv
package ppl_pkg;
  localparam int PORTS     = 4;
  localparam int MIN_PORTS = 2;

  // strobes from control to datapath, one lane per port
  typedef struct packed {
    logic [PORTS-1:0] active;
    logic [PORTS-1:0] trip;
    logic [PORTS-1:0] pwrOn;
    logic [PORTS-1:0] pwrOff;
    logic [PORTS-1:0] chgClr;
  } portStrb_t;
endpackage

// File: rtl/ppl_ctrl.sv
module ppl_ctrl
  import ppl_pkg::*;
#(
  parameter int DEB_CYCLES = 4,
  localparam int CNT_W = $clog2(DEB_CYCLES + 1),
  localparam int PC_W  = $clog2(PORTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PORTS-1:0] ocN,
  input  logic             gangMode,
  input  logic [PC_W-1:0]  portCount,
  input  logic [PORTS-1:0] pwrSet,
  input  logic [PORTS-1:0] pwrClr,
  input  logic [PORTS-1:0] chgClr,
  output portStrb_t        strb
);
  logic [PC_W-1:0]  cntEff;
  logic [PORTS-1:0] activeV;
  logic [PORTS-1:0] tripRaw;
  logic [PORTS-1:0] laneKeep;

  // clamp the configured count into the legal range
  always_comb begin
    if (portCount < PC_W'(MIN_PORTS))  cntEff = PC_W'(MIN_PORTS);
    else if (portCount > PC_W'(PORTS)) cntEff = PC_W'(PORTS);
    else                               cntEff = portCount;
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic             rawOc;
    logic [CNT_W-1:0] debCnt;

    assign activeV[p] = (PC_W'(p) < cntEff);
    assign rawOc      = ~ocN[p];

    // saturating run-length counter of sampled over-current
    always_ff @(posedge clk) begin
      if (!rst_n)                             debCnt <= '0;
      else if (!rawOc)                        debCnt <= '0;
      else if (debCnt != CNT_W'(DEB_CYCLES))  debCnt <= debCnt + 1'b1;
    end

    // one trip event per continuous assertion
    assign tripRaw[p] = rawOc && (debCnt == CNT_W'(DEB_CYCLES - 1));

    a_r3_single_trip : assert property (@(posedge clk) disable iff (!rst_n)
      tripRaw[p] |=> !tripRaw[p]);
  end

  // gang mode keeps only the port 1 lane
  assign laneKeep = gangMode ? PORTS'(1) : '1;

  assign strb.active = activeV;
  assign strb.trip   = tripRaw & laneKeep & activeV;
  assign strb.pwrOn  = pwrSet  & laneKeep & activeV;
  assign strb.pwrOff = pwrClr  & laneKeep & activeV;
  assign strb.chgClr = chgClr  & laneKeep & activeV;
endmodule

// File: rtl/ppl_datapath.sv
module ppl_datapath
  import ppl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  portStrb_t        strb,
  input  logic             gangMode,
  input  logic             suspend,
  input  logic             eepromPresent,
  input  logic [PORTS-1:0] portEn,
  input  logic [PORTS-1:0] ledManual,
  input  logic [PORTS-1:0] manGreen,
  input  logic [PORTS-1:0] manAmber,
  output logic [PORTS-1:0] pwrEnN,
  output logic [PORTS-1:0] ledGreen,
  output logic [PORTS-1:0] ledAmber,
  output logic [PORTS-1:0] ocChange
);
  logic [PORTS-1:0] powerOn;
  logic [PORTS-1:0] chg;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic effPow, effChg, autoG, autoA, selG, selA, lit;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        powerOn[p] <= 1'b0;
        chg[p]     <= 1'b0;
      end else if (!strb.active[p]) begin
        powerOn[p] <= 1'b0;
        chg[p]     <= 1'b0;
      end else if (strb.trip[p]) begin
        powerOn[p] <= 1'b0;
        chg[p]     <= 1'b1;
      end else begin
        if (strb.pwrOff[p])     powerOn[p] <= 1'b0;
        else if (strb.pwrOn[p]) powerOn[p] <= 1'b1;
        if (strb.chgClr[p])     chg[p] <= 1'b0;
      end
    end

    // gang mode: every port reflects the shared port 1 state
    assign effPow = gangMode ? powerOn[0] : powerOn[p];
    assign effChg = gangMode ? chg[0]     : chg[p];

    assign autoA = effChg;
    assign autoG = !effChg && effPow && portEn[p];
    assign selG  = ledManual[p] ? manGreen[p] : autoG;
    assign selA  = ledManual[p] ? manAmber[p] : autoA;
    assign lit   = strb.active[p] && !suspend;

    assign ledGreen[p] = lit && selG;
    assign ledAmber[p] = lit && selA && !eepromPresent;
    assign ocChange[p] = strb.active[p] && effChg;
    assign pwrEnN[p]   = !(powerOn[p] && strb.active[p] && (p == 0 || !gangMode));

    a_r3_trip_cuts_power : assert property (@(posedge clk) disable iff (!rst_n)
      strb.trip[p] |=> (!powerOn[p] && chg[p]));

    a_r4_chg_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (chg[p] && strb.active[p] && !strb.chgClr[p]) |=> chg[p]);

    a_r10_inactive_cleared : assert property (@(posedge clk) disable iff (!rst_n)
      !strb.active[p] |=> (!powerOn[p] && !chg[p]));

    a_r5_gang_shared_fault : assert property (@(posedge clk) disable iff (!rst_n)
      (gangMode && strb.trip[0]) |=> (!gangMode || !strb.active[p] || ocChange[p]));
  end

  a_r8_dark_in_suspend : assert property (@(posedge clk) disable iff (!rst_n)
    suspend |-> (ledGreen == '0 && ledAmber == '0));

  a_r9_no_amber_shared : assert property (@(posedge clk) disable iff (!rst_n)
    eepromPresent |-> (ledAmber == '0));
endmodule

// File: rtl/port_pwr_led_ctrl.sv
module port_pwr_led_ctrl
  import ppl_pkg::*;
#(
  parameter int DEB_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ocN,
  input  logic       gangMode,
  input  logic [2:0] portCount,
  input  logic [3:0] pwrSet,
  input  logic [3:0] pwrClr,
  input  logic [3:0] chgClr,
  input  logic [3:0] portEn,
  input  logic [3:0] ledManual,
  input  logic [3:0] manGreen,
  input  logic [3:0] manAmber,
  input  logic       suspend,
  input  logic       eepromPresent,
  output logic [3:0] pwrEnN,
  output logic [3:0] ledGreen,
  output logic [3:0] ledAmber,
  output logic [3:0] ocChange
);
  portStrb_t strb;

  ppl_ctrl #(.DEB_CYCLES(DEB_CYCLES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ocN       (ocN),
    .gangMode  (gangMode),
    .portCount (portCount),
    .pwrSet    (pwrSet),
    .pwrClr    (pwrClr),
    .chgClr    (chgClr),
    .strb      (strb)
  );

  ppl_datapath u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .strb          (strb),
    .gangMode      (gangMode),
    .suspend       (suspend),
    .eepromPresent (eepromPresent),
    .portEn        (portEn),
    .ledManual     (ledManual),
    .manGreen      (manGreen),
    .manAmber      (manAmber),
    .pwrEnN        (pwrEnN),
    .ledGreen      (ledGreen),
    .ledAmber      (ledAmber),
    .ocChange      (ocChange)
  );
endmodule

// File: tb/tb_port_pwr_led_ctrl.sv
module tb_port_pwr_led_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] ocN, pwrSet, pwrClr, chgClr, portEn, ledManual, manGreen, manAmber;
  logic       gangMode, suspend, eepromPresent;
  logic [2:0] portCount;
  logic [3:0] pwrEnN, ledGreen, ledAmber, ocChange;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [3:0] pe;
    logic [3:0] g;
    logic [3:0] a;
    logic [3:0] c;
    string      tag;
  } expItem_t;

  expItem_t sb[$];

  always #4 clk = ~clk;

  port_pwr_led_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ocN(ocN), .gangMode(gangMode), .portCount(portCount),
    .pwrSet(pwrSet), .pwrClr(pwrClr), .chgClr(chgClr), .portEn(portEn),
    .ledManual(ledManual), .manGreen(manGreen), .manAmber(manAmber),
    .suspend(suspend), .eepromPresent(eepromPresent),
    .pwrEnN(pwrEnN), .ledGreen(ledGreen), .ledAmber(ledAmber), .ocChange(ocChange)
  );

  // driver: push the outputs expected after the coming edge, then move on
  task automatic chk(input logic [3:0] pe, g, a, c, input string tag);
    expItem_t it;
    it.pe = pe; it.g = g; it.a = a; it.c = c; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    pwrSet = '0; pwrClr = '0; chgClr = '0;
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        expItem_t it;
        it = sb.pop_front();
        total++;
        if (pwrEnN !== it.pe || ledGreen !== it.g || ledAmber !== it.a || ocChange !== it.c) begin
          bad++;
          $display("FAIL %s: got pe=%b g=%b a=%b c=%b exp pe=%b g=%b a=%b c=%b",
                   it.tag, pwrEnN, ledGreen, ledAmber, ocChange, it.pe, it.g, it.a, it.c);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ocN = 4'hF; gangMode = 1'b0; portCount = 3'd4;
    pwrSet = '0; pwrClr = '0; chgClr = '0; portEn = 4'hF;
    ledManual = '0; manGreen = '0; manAmber = '0; suspend = 1'b0; eepromPresent = 1'b0;
    @(negedge clk);
    chk(4'b1111, 4'b0000, 4'b0000, 4'b0000, "R1 in reset");
    rst_n = 1'b1;
    chk(4'b1111, 4'b0000, 4'b0000, 4'b0000, "R1 after reset");

    pwrSet = 4'b0101; chk(4'b1010, 4'b0101, 4'b0000, 4'b0000, "R2 power 0,2");
    pwrSet = 4'b1010; chk(4'b0000, 4'b1111, 4'b0000, 4'b0000, "R2 power 1,3");
    pwrClr = 4'b0010; chk(4'b0010, 4'b1101, 4'b0000, 4'b0000, "R2 unpower 1");

    // glitch one cycle short of the filter
    ocN = 4'b1110;
    for (int i = 0; i < 3; i++) chk(4'b0010, 4'b1101, 4'b0000, 4'b0000, "R3 short glitch");
    ocN = 4'hF; chk(4'b0010, 4'b1101, 4'b0000, 4'b0000, "R3 glitch ignored");

    // full-length fault on port 2
    ocN = 4'b1011;
    for (int i = 0; i < 3; i++) chk(4'b0010, 4'b1101, 4'b0000, 4'b0000, "R3 filtering");
    chk(4'b0110, 4'b1001, 4'b0100, 4'b0100, "R3 R6 trip port2");
    ocN = 4'hF; chk(4'b0110, 4'b1001, 4'b0100, 4'b0100, "R4 flag held");
    pwrSet = 4'b0100; chk(4'b0010, 4'b1001, 4'b0100, 4'b0100, "R6 amber over green");
    chgClr = 4'b0100; chk(4'b0010, 4'b1101, 4'b0000, 4'b0000, "R4 flag cleared");

    // trip and clear in the same cycle on port 3
    ocN = 4'b0111;
    for (int i = 0; i < 3; i++) chk(4'b0010, 4'b1101, 4'b0000, 4'b0000, "R3 filtering p3");
    chgClr = 4'b1000; chk(4'b1010, 4'b0101, 4'b1000, 4'b1000, "R4 trip beats clear");
    pwrSet = 4'b1000; chk(4'b0010, 4'b0101, 4'b1000, 4'b1000, "R4 repower during fault");
    chk(4'b0010, 4'b0101, 4'b1000, 4'b1000, "R4 no retrip while held");
    ocN = 4'hF; chgClr = 4'b1000; chk(4'b0010, 4'b1101, 4'b0000, 4'b0000, "R4 clear p3");

    portEn = 4'b1011; chk(4'b0010, 4'b1001, 4'b0000, 4'b0000, "R6 disabled port dark");
    portEn = 4'hF;
    ledManual = 4'b0001; manAmber = 4'b0001;
    chk(4'b0010, 4'b1100, 4'b0001, 4'b0000, "R7 manual amber");
    eepromPresent = 1'b1; chk(4'b0010, 4'b1100, 4'b0000, 4'b0000, "R9 amber suppressed");
    eepromPresent = 1'b0; suspend = 1'b1;
    chk(4'b0010, 4'b0000, 4'b0000, 4'b0000, "R8 suspend dark");
    suspend = 1'b0; ledManual = '0; manAmber = '0;
    chk(4'b0010, 4'b1101, 4'b0000, 4'b0000, "R6 back to auto");

    // port count
    portCount = 3'd2; pwrSet = 4'b1000;
    chk(4'b1110, 4'b0001, 4'b0000, 4'b0000, "R10 shrink to 2");
    portCount = 3'd3; chk(4'b1110, 4'b0001, 4'b0000, 4'b0000, "R10 count 3 stays off");
    portCount = 3'd0; pwrSet = 4'b0100;
    chk(4'b1110, 4'b0001, 4'b0000, 4'b0000, "R10 count 0 acts as 2");
    portCount = 3'd7; pwrSet = 4'b1110;
    chk(4'b0000, 4'b1111, 4'b0000, 4'b0000, "R10 count 7 acts as 4");

    // gang mode
    gangMode = 1'b1; chk(4'b1110, 4'b1111, 4'b0000, 4'b0000, "R5 gang single enable");
    pwrClr = 4'b1000; chk(4'b1110, 4'b1111, 4'b0000, 4'b0000, "R5 other clear ignored");
    pwrClr = 4'b0001; chk(4'b1111, 4'b0000, 4'b0000, 4'b0000, "R5 gang off");
    pwrSet = 4'b0001; chk(4'b1110, 4'b1111, 4'b0000, 4'b0000, "R5 gang on");
    ocN = 4'b0001;
    for (int i = 0; i < 5; i++) chk(4'b1110, 4'b1111, 4'b0000, 4'b0000, "R5 other sense ignored");
    ocN = 4'b1110;
    for (int i = 0; i < 3; i++) chk(4'b1110, 4'b1111, 4'b0000, 4'b0000, "R5 gang filtering");
    chk(4'b1111, 4'b0000, 4'b1111, 4'b1111, "R5 gang trip");
    ocN = 4'hF; chgClr = 4'b0001; chk(4'b1111, 4'b0000, 4'b0000, 4'b0000, "R5 gang clear");

    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule